// File: doc/BRIEF.md
# Scanline Table-Driven Register Writer

This block drives a set of peripheral registers from tables held in memory, one step per video scan line. Each of N channels owns a table made of count-prefixed entries. The table starts at a configured 24-bit location: an 8-bit bank in the upper byte and a 16-bit offset in the lower two bytes. When a frame begins, every enabled channel reloads its pointer and fetches its first count. On each line strobe after that, every channel that is still running takes one step and writes to a register in the 0x21xx page.

A channel works in one of two formats. In the byte-list format, the count says how many data bytes follow it, and one of those bytes is written on each line. In the repeat-word format, a single little-endian word follows the count, and that word is written on each of the next count lines. A count of zero ends the table, and the channel stays silent until the next frame. One sequencer serves all channels in ascending order, through a memory read port with one cycle of latency and a single register write port. Line timing and the target registers lie outside this block.

Top module: `scanline_reg_writer`

## Requirements
- R1: After reset, busy_o, mem_rd_o and reg_we_o are low, and every channel is stopped.
- R2: A frame strobe makes no register write. In ascending channel order, it reads the count byte of each enabled channel at that channel's configured base, and reads nothing for disabled channels.
- R3: Byte format (bit 1 of the channel's mode byte is 0, e.g. 0x00). For a count n, the next n line strobes each write one data byte, in table order.
- R4: Word format (bit 1 of the mode byte is 1, e.g. 0x02). For a count n, each of the next n line strobes writes the byte at pointer and then the byte at pointer+1, both to the same register address.
- R5: Only the low 7 bits of a count byte are used, so bit 7 is ignored. A count of zero stops the channel: it makes no further reads or writes until the next frame strobe.
- R6: Every register write goes to address {0x21, dest}, where dest is the channel's 8-bit destination byte.
- R7: Within one line, all running enabled channels are served, and lower channel numbers write first.
- R8: Bit i of en_mask_i enables channel i. A disabled channel makes no reads and no writes.
- R9: A strobe is accepted only when busy_o is low, and a strobe that arrives while busy_o is high is ignored. If both strobes arrive in the same cycle, the frame strobe wins and the line strobe is dropped.
- R10: The pointer advances only in its 16-bit offset, which wraps from 0xFFFF to 0x0000 within the same bank.
- R11: A word-format table {112, 0x0000, 1, 0x0080, 0} writes 0x00,0x00 on each of lines 1 to 112, writes 0x80,0x00 on line 113, and writes nothing afterwards.
- R12: mem_rdata_i is taken to be valid in the cycle after mem_rd_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame strobe: reload the table pointers |
| line_start_i | input | 1 | Line strobe: each running channel takes one step |
| en_mask_i | input | N | Channel enable, bit i for channel i |
| cfg_mode_i | input | N*8 | Mode byte per channel; bit 1 selects word format |
| cfg_dest_i | input | N*8 | Low byte of the destination address per channel |
| cfg_base_i | input | N*24 | Table base per channel: bank in bits 23:16, offset in bits 15:0 |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 24 | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the request |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 16 | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| busy_o | output | 1 | High while a strobe is being served |

## Verification
A channel whose remaining count is wrong will end its entry on the wrong line. At the ports this appears within a few lines, as the first value of the next entry arriving too early or too late. A pointer that is off by one, or that carries into the bank byte, puts misplaced data or a spurious count into the write stream on the very next line. A stopped flag that is lost or set by mistake shows up on the first line after the bad frame, as writes that should not occur or writes that are missing. A scoreboard checks the written address and data stream in order, and logs the addresses read at each frame start. This catches ordering faults between channels as soon as two channels share a line.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int unsigned ADDR_W   = 24;
  localparam int unsigned OFF_W    = 16;
  localparam int unsigned CNT_W    = 7;
  localparam logic [7:0]  REG_PAGE = 8'h21;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_BASE, OP_COUNT, OP_BYTE_STEP, OP_WORD_STEP
  } chan_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PICK, S_CNT_RD, S_CNT_RSP, S_D0_RD, S_D0_RSP, S_D1_RD, S_D1_RSP
  } seq_state_e;

  // offset advances, bank is kept
  function automatic addr_t addr_add(addr_t a, logic [1:0] inc);
    addr_add = {a[ADDR_W-1:OFF_W], a[OFF_W-1:0] + OFF_W'(inc)};
  endfunction
endpackage

// File: rtl/srw_pick.sv
module srw_pick #(
  parameter  int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     mask_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/srw_chan.sv
module srw_chan
  import srw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sel_i,
  input  chan_op_e         op_i,
  input  addr_t            base_i,
  input  logic [CNT_W-1:0] cnt_data_i,
  output addr_t            ptr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             live_o
);
  addr_t            ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else begin
      if (clr_i) live_q <= 1'b0;
      if (sel_i) begin
        unique case (op_i)
          OP_BASE: ptr_q <= base_i;
          OP_COUNT: begin
            cnt_q  <= cnt_data_i;
            live_q <= |cnt_data_i;
            if (|cnt_data_i) ptr_q <= addr_add(ptr_q, 2'd1);
          end
          OP_BYTE_STEP: begin
            ptr_q <= addr_add(ptr_q, 2'd1);
            cnt_q <= cnt_q - 1'b1;
          end
          OP_WORD_STEP: begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) ptr_q <= addr_add(ptr_q, 2'd2);
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign cnt_o  = cnt_q;
  assign live_o = live_q;
endmodule

// File: rtl/srw_seq.sv
module srw_seq
  import srw_pkg::*;
#(
  parameter  int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             line_start_i,
  input  logic [N-1:0]     en_mask_i,
  input  logic [N-1:0]     live_i,
  input  addr_t            ptr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             word_i,
  input  logic [7:0]       rdata_i,
  output logic [IDX_W-1:0] chan_idx_o,
  output chan_op_e         op_o,
  output logic             clr_o,
  output logic             mem_rd_o,
  output addr_t            mem_addr_o,
  output logic             reg_we_o,
  output logic [7:0]       reg_wdata_o,
  output logic             busy_o
);
  seq_state_e       state_q, state_d;
  logic [N-1:0]     pend_q;
  logic             frame_q;
  logic [IDX_W-1:0] idx_q;
  logic             pk_any;
  logic [IDX_W-1:0] pk_idx;
  logic             last;

  srw_pick #(.N(N)) u_pick (
    .mask_i(pend_q),
    .any_o (pk_any),
    .idx_o (pk_idx)
  );

  assign last = (cnt_i == CNT_W'(1));

  always_comb begin
    state_d     = state_q;
    op_o        = OP_NONE;
    chan_idx_o  = idx_q;
    mem_rd_o    = 1'b0;
    mem_addr_o  = ptr_i;
    reg_we_o    = 1'b0;
    reg_wdata_o = rdata_i;
    unique case (state_q)
      S_IDLE: if (frame_start_i || line_start_i) state_d = S_PICK;
      S_PICK: begin
        chan_idx_o = pk_idx;
        if (!pk_any) state_d = S_IDLE;
        else if (frame_q) begin
          op_o    = OP_BASE;
          state_d = S_CNT_RD;
        end else state_d = S_D0_RD;
      end
      S_CNT_RD: begin
        mem_rd_o = 1'b1;
        state_d  = S_CNT_RSP;
      end
      S_CNT_RSP: begin
        op_o    = OP_COUNT;
        state_d = S_PICK;
      end
      S_D0_RD: begin
        mem_rd_o = 1'b1;
        state_d  = S_D0_RSP;
      end
      S_D0_RSP: begin
        reg_we_o = 1'b1;
        if (word_i) state_d = S_D1_RD;
        else begin
          op_o    = OP_BYTE_STEP;
          state_d = last ? S_CNT_RD : S_PICK;
        end
      end
      S_D1_RD: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = addr_add(ptr_i, 2'd1);
        state_d    = S_D1_RSP;
      end
      S_D1_RSP: begin
        reg_we_o = 1'b1;
        op_o     = OP_WORD_STEP;
        state_d  = last ? S_CNT_RD : S_PICK;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign clr_o  = (state_q == S_IDLE) && frame_start_i;
  assign busy_o = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pend_q  <= '0;
      frame_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE) begin
        if (frame_start_i) begin
          pend_q  <= en_mask_i;
          frame_q <= 1'b1;
        end else if (line_start_i) begin
          pend_q  <= en_mask_i & live_i;
          frame_q <= 1'b0;
        end
      end else if (state_q == S_PICK && pk_any) begin
        idx_q          <= pk_idx;
        pend_q[pk_idx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/scanline_reg_writer.sv
module scanline_reg_writer
  import srw_pkg::*;
#(
  parameter  int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_start_i,
  input  logic            line_start_i,
  input  logic [N-1:0]    en_mask_i,
  input  logic [N*8-1:0]  cfg_mode_i,
  input  logic [N*8-1:0]  cfg_dest_i,
  input  logic [N*24-1:0] cfg_base_i,
  output logic            mem_rd_o,
  output logic [23:0]     mem_addr_o,
  input  logic [7:0]      mem_rdata_i,
  output logic            reg_we_o,
  output logic [15:0]     reg_addr_o,
  output logic [7:0]      reg_wdata_o,
  output logic            busy_o
);
  addr_t            ptr_w   [N];
  logic [CNT_W-1:0] cnt_w   [N];
  logic [7:0]       dest_w  [N];
  logic [N-1:0]     word_w;
  logic [N-1:0]     live_w;
  logic [N-1:0]     sel_w;
  logic [IDX_W-1:0] chan_idx;
  chan_op_e         op;
  logic             clr;
  logic             unused_mode;

  assign unused_mode = ^cfg_mode_i;

  for (genvar i = 0; i < N; i++) begin : g_chan
    assign word_w[i] = cfg_mode_i[i*8+1];
    assign dest_w[i] = cfg_dest_i[i*8 +: 8];
    assign sel_w[i]  = (op != OP_NONE) && (chan_idx == IDX_W'(i));

    srw_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .sel_i     (sel_w[i]),
      .op_i      (op),
      .base_i    (cfg_base_i[i*24 +: 24]),
      .cnt_data_i(mem_rdata_i[CNT_W-1:0]),
      .ptr_o     (ptr_w[i]),
      .cnt_o     (cnt_w[i]),
      .live_o    (live_w[i])
    );
  end

  srw_seq #(.N(N)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .line_start_i (line_start_i),
    .en_mask_i    (en_mask_i),
    .live_i       (live_w),
    .ptr_i        (ptr_w[chan_idx]),
    .cnt_i        (cnt_w[chan_idx]),
    .word_i       (word_w[chan_idx]),
    .rdata_i      (mem_rdata_i),
    .chan_idx_o   (chan_idx),
    .op_o         (op),
    .clr_o        (clr),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .reg_we_o     (reg_we_o),
    .reg_wdata_o  (reg_wdata_o),
    .busy_o       (busy_o)
  );

  assign reg_addr_o = {REG_PAGE, dest_w[chan_idx]};
endmodule

// File: rtl/srw_chk.sv
module srw_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        frame_start_i,
  input logic        line_start_i,
  input logic        mem_rd_o,
  input logic        reg_we_o,
  input logic [15:0] reg_addr_o,
  input logic        busy_o
);
  // R6
  page_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> reg_addr_o[15:8] == 8'h21);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_rd_o && !reg_we_o));

  // R9
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(frame_start_i || line_start_i));

  // R12
  data_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(mem_rd_o));

  // R12
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && reg_we_o));
endmodule

bind scanline_reg_writer srw_chk u_srw_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .line_start_i (line_start_i),
  .mem_rd_o     (mem_rd_o),
  .reg_we_o     (reg_we_o),
  .reg_addr_o   (reg_addr_o),
  .busy_o       (busy_o)
);

// File: tb/scanline_reg_writer_bench.sv
module scanline_reg_writer_bench;
  localparam int NCH = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_start = 1'b0;
  logic              line_start = 1'b0;
  logic [NCH-1:0]    en_mask = '0;
  logic [NCH*8-1:0]  cfg_mode = '0;
  logic [NCH*8-1:0]  cfg_dest = '0;
  logic [NCH*24-1:0] cfg_base = '0;
  logic              mem_rd_o;
  logic [23:0]       mem_addr_o;
  logic [7:0]        mem_rdata = '0;
  logic              reg_we_o;
  logic [15:0]       reg_addr_o;
  logic [7:0]        reg_wdata_o;
  logic              busy_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string cur_req = "R1";

  typedef struct {
    logic [15:0] a;
    logic [7:0]  d;
    string       r;
  } exp_t;
  exp_t        exq[$];
  logic [23:0] rd_log[$];
  bit [7:0]    mem[int];

  always #5 clk = ~clk;

  scanline_reg_writer #(.N(NCH)) u_scanline_reg_writer (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .frame_start_i(frame_start),
    .line_start_i (line_start),
    .en_mask_i    (en_mask),
    .cfg_mode_i   (cfg_mode),
    .cfg_dest_i   (cfg_dest),
    .cfg_base_i   (cfg_base),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rdata_i  (mem_rdata),
    .reg_we_o     (reg_we_o),
    .reg_addr_o   (reg_addr_o),
    .reg_wdata_o  (reg_wdata_o),
    .busy_o       (busy_o)
  );

  // memory model, one cycle read latency
  always @(posedge clk)
    if (mem_rd_o) mem_rdata <= mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : 8'h00;

  // monitor
  always @(negedge clk) begin
    if (rst_n && mem_rd_o) rd_log.push_back(mem_addr_o);
    if (rst_n && reg_we_o) begin
      compared++;
      if (exq.size() == 0) begin
        mismatched++;
        $display("FAIL %s: unexpected write addr=%h data=%h expected none", cur_req, reg_addr_o, reg_wdata_o);
      end else begin
        exp_t e;
        e = exq.pop_front();
        if (reg_addr_o !== e.a || reg_wdata_o !== e.d) begin
          mismatched++;
          $display("FAIL %s: write addr=%h data=%h expected addr=%h data=%h", e.r, reg_addr_o, reg_wdata_o, e.a, e.d);
        end
      end
    end
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] dest, input logic [7:0] d, input string r);
    exp_t e;
    e.a = {8'h21, dest};
    e.d = d;
    e.r = r;
    exq.push_back(e);
  endtask

  task automatic set_chan(input int i, input logic [7:0] mode, input logic [7:0] dest, input logic [23:0] base);
    cfg_mode[i*8 +: 8]   = mode;
    cfg_dest[i*8 +: 8]   = dest;
    cfg_base[i*24 +: 24] = base;
  endtask

  task automatic wait_idle();
    @(posedge clk); #1;
    while (busy_o) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse(input bit fr, input bit ln);
    @(posedge clk); #1;
    frame_start = fr;
    line_start  = ln;
    @(posedge clk); #1;
    frame_start = 1'b0;
    line_start  = 1'b0;
    wait_idle();
  endtask

  task automatic drained(input string r);
    check(r, exq.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", busy_o, 0);
    check("R1", mem_rd_o, 0);
    check("R1", reg_we_o, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1", {busy_o, mem_rd_o, reg_we_o}, 0);

    // R11 / R4 / R2: repeat-word table of the example
    cur_req = "R11";
    mem[32'h018000] = 8'd112; mem[32'h018001] = 8'h00; mem[32'h018002] = 8'h00;
    mem[32'h018003] = 8'd1;   mem[32'h018004] = 8'h80; mem[32'h018005] = 8'h00;
    mem[32'h018006] = 8'd0;
    set_chan(0, 8'h02, 8'h0D, 24'h018000);
    en_mask = 4'b0001;
    rd_log.delete();
    pulse(1, 0);
    check("R2", rd_log.size(), 1);
    if (rd_log.size() > 0) check("R2", rd_log[0], 24'h018000);
    for (int ln = 1; ln <= 115; ln++) begin
      if (ln <= 112) begin
        push(8'h0D, 8'h00, "R4"); push(8'h0D, 8'h00, "R4");
      end else if (ln == 113) begin
        push(8'h0D, 8'h80, "R11"); push(8'h0D, 8'h00, "R11");
      end
      pulse(0, 1);
    end
    drained("R11");

    // R3 / R5: byte list, count bit 7 ignored, zero ends
    cur_req = "R5";
    mem[32'h020010] = 8'd3;
    mem[32'h020011] = 8'hA1; mem[32'h020012] = 8'hA2; mem[32'h020013] = 8'hA3;
    mem[32'h020014] = 8'h82;
    mem[32'h020015] = 8'hB1; mem[32'h020016] = 8'hB2;
    mem[32'h020017] = 8'd0;
    set_chan(1, 8'h00, 8'h22, 24'h020010);
    en_mask = 4'b0010;
    pulse(1, 0);
    push(8'h22, 8'hA1, "R3"); pulse(0, 1);
    push(8'h22, 8'hA2, "R3"); pulse(0, 1);
    push(8'h22, 8'hA3, "R3"); pulse(0, 1);
    push(8'h22, 8'hB1, "R5"); pulse(0, 1);
    push(8'h22, 8'hB2, "R5"); pulse(0, 1);
    rd_log.delete();
    pulse(0, 1);
    pulse(0, 1);
    check("R5", rd_log.size(), 0);
    drained("R3");

    // R7 / R8 / R2: several channels, ascending order, channel 1 masked
    cur_req = "R8";
    mem[32'h030000] = 8'd2; mem[32'h030001] = 8'h34; mem[32'h030002] = 8'h12; mem[32'h030003] = 8'd0;
    mem[32'h031000] = 8'd5; mem[32'h031001] = 8'hEE;
    mem[32'h032000] = 8'd1; mem[32'h032001] = 8'hC1; mem[32'h032002] = 8'd1; mem[32'h032003] = 8'hC2;
    mem[32'h032004] = 8'd0;
    mem[32'h033000] = 8'd3; mem[32'h033001] = 8'hD1; mem[32'h033002] = 8'hD2; mem[32'h033003] = 8'hD3;
    mem[32'h033004] = 8'd0;
    set_chan(0, 8'h02, 8'h40, 24'h030000);
    set_chan(1, 8'h00, 8'h41, 24'h031000);
    set_chan(2, 8'h00, 8'h42, 24'h032000);
    set_chan(3, 8'h00, 8'h43, 24'h033000);
    en_mask = 4'b1101;
    rd_log.delete();
    pulse(1, 0);
    check("R2", rd_log.size(), 3);
    if (rd_log.size() == 3) begin
      check("R2", rd_log[0], 24'h030000);
      check("R2", rd_log[1], 24'h032000);
      check("R2", rd_log[2], 24'h033000);
    end
    for (int ln = 0; ln < 2; ln++) begin
      push(8'h40, 8'h34, "R7"); push(8'h40, 8'h12, "R7");
      push(8'h42, (ln == 0) ? 8'hC1 : 8'hC2, "R7");
      push(8'h43, (ln == 0) ? 8'hD1 : 8'hD2, "R7");
      pulse(0, 1);
    end
    push(8'h43, 8'hD3, "R7");
    pulse(0, 1);
    pulse(0, 1);
    drained("R7");

    // R10: offset wraps inside the bank
    cur_req = "R10";
    mem[32'h05FFFE] = 8'd2; mem[32'h05FFFF] = 8'h11;
    mem[32'h050000] = 8'h22; mem[32'h050001] = 8'd0;
    mem[32'h060000] = 8'h99; mem[32'h060001] = 8'h05;
    set_chan(2, 8'h00, 8'h50, 24'h05FFFE);
    en_mask = 4'b0100;
    pulse(1, 0);
    push(8'h50, 8'h11, "R10"); pulse(0, 1);
    push(8'h50, 8'h22, "R10"); pulse(0, 1);
    pulse(0, 1);
    drained("R10");

    // R9: strobes while busy ignored, frame beats line
    cur_req = "R9";
    mem[32'h070000] = 8'd4;
    mem[32'h070001] = 8'hE1; mem[32'h070002] = 8'hE2;
    mem[32'h070003] = 8'hE3; mem[32'h070004] = 8'hE4;
    mem[32'h070005] = 8'd0;
    set_chan(0, 8'h00, 8'h60, 24'h070000);
    en_mask = 4'b0001;
    pulse(1, 0);
    push(8'h60, 8'hE1, "R9");
    @(posedge clk); #1 line_start = 1'b1;
    @(posedge clk); #1 line_start = 1'b0;
    check("R9", busy_o, 1);
    @(posedge clk); #1 line_start = 1'b1;
    @(posedge clk); #1 line_start = 1'b0;
    wait_idle();
    drained("R9");
    push(8'h60, 8'hE2, "R9"); pulse(0, 1);
    pulse(1, 1);
    drained("R9");
    push(8'h60, 8'hE1, "R9"); pulse(0, 1);
    drained("R9");

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule